// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division over many clock cycles and keeps its results in a dedicated pair of result registers, HI and LO. It does not write them to a general register. A one-cycle start request supplies an operation code and two operands. The unit then works for a fixed number of cycles with `busy` high. It finishes with a one-cycle `done` pulse, and in that same cycle the new HI and LO values appear on the read ports.

A multiply leaves the full 64-bit product split across HI (upper word) and LO (lower word). A divide leaves the quotient in LO and the remainder in HI. Signed and unsigned forms of both operations are chosen per request. The two read ports serve move-from-HI and move-from-LO. A three-operand multiply is built outside the block: a multiply followed by a read of LO. The block does not stall a pipeline and does not connect to a register file.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset `busy` and `done` are 0 and both `hiOut` and `loOut` read 0.
- R2: `opSel` value 0 selects a signed multiply: {`hiOut`,`loOut`} becomes the 64-bit two's-complement product of `srcA` and `srcB`.
- R3: `opSel` value 1 selects an unsigned multiply: {`hiOut`,`loOut`} becomes the 64-bit unsigned product.
- R4: `opSel` value 2 selects a signed divide. `loOut` becomes the quotient of `srcA`/`srcB`, truncated toward zero. `hiOut` becomes the remainder, which carries the sign of `srcA`. The case -2^31 / -1 yields quotient 0x80000000 and remainder 0.
- R5: `opSel` value 3 selects an unsigned divide. `loOut` becomes the quotient and `hiOut` the remainder.
- R6: A divide with `srcB` equal to 0, signed or unsigned, sets `loOut` to 0xFFFFFFFF and `hiOut` to the unmodified `srcA`. No other signal reacts.
- R7: A start request sampled while the unit is idle is accepted. `busy` is then high for exactly 33 cycles. `done` follows as a single-cycle pulse with `busy` low, and the new result is readable in that cycle.
- R8: A start request made while `busy` is high is ignored. The running operation's result and timing are unchanged, and no second operation follows.
- R9: `hiOut` and `loOut` keep their previous values at every cycle in which `done` is not high, including throughout a computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin an operation |
| opSel | input | 2 | Operation: 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| srcA | input | 32 | Multiplicand or dividend |
| srcB | input | 32 | Multiplier or divisor |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| hiOut | output | 32 | HI register (product upper word or remainder) |
| loOut | output | 32 | LO register (product lower word or quotient) |

## Verification
A wrong iteration count or a stuck control state shows at the ports within one operation. The `busy` window is no longer 33 cycles, or `done` never appears. A fault in the shift-add or restoring step corrupts HI/LO in the `done` cycle of the first operation whose operand bits reach the faulty path. Random operands expose it within a few operations. A sign-handling fault surfaces only for negative operands, so directed cases cover every sign pairing. Early writes of HI/LO show mid-computation as a change on the read ports before `done`.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MUL_U = 2'd1,
    OP_DIV_S = 2'd2,
    OP_DIV_U = 2'd3
  } mdOp_e;

  typedef struct packed {
    logic load;    // capture operands, clear accumulator
    logic step;    // one shift-add or restoring iteration
    logic commit;  // write HI/LO
  } mdStrobe_t;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  output mdStrobe_t strobes,
  output logic      busy,
  output logic      done
);
  localparam int CNT_W = $clog2(WIDTH) + 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} ctrlState_e;

  ctrlState_e state;
  logic [CNT_W-1:0] stepCnt;
  logic doneReg;

  always_comb begin
    strobes.load   = (state == S_IDLE) && startReq;
    strobes.step   = (state == S_RUN);
    strobes.commit = (state == S_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= strobes.commit;
      case (state)
        S_IDLE: if (startReq) begin
          state   <= S_RUN;
          stepCnt <= '0;
        end
        S_RUN: begin
          if (stepCnt == LAST_STEP) state <= S_FIN;
          stepCnt <= stepCnt + 1'b1;
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneReg;
endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdStrobe_t        strobes,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] resHi,
  output logic [WIDTH-1:0] resLo
);
  localparam int DW = 2 * WIDTH;

  logic             isDiv, negRes, negRem, divZero;
  logic [WIDTH-1:0] dividendRaw, bMag, accLo;
  logic [WIDTH:0]   accHi;

  // operand conditioning
  logic             opSigned, aNeg, bNeg;
  logic [WIDTH-1:0] aMag, bMagIn;
  always_comb begin
    opSigned = (opSel == OP_MUL_S) || (opSel == OP_DIV_S);
    aNeg     = opSigned && srcA[WIDTH-1];
    bNeg     = opSigned && srcB[WIDTH-1];
    aMag     = aNeg ? (~srcA + 1'b1) : srcA;
    bMagIn   = bNeg ? (~srcB + 1'b1) : srcB;
  end

  // one multiply iteration: conditional add, then shift right
  logic [WIDTH:0] mulSum;
  // one restoring divide iteration: shift left, trial subtract
  logic [WIDTH:0] divShift, divDiff;
  always_comb begin
    mulSum   = {1'b0, accHi[WIDTH-1:0]} + {1'b0, (accLo[0] ? bMag : '0)};
    divShift = {accHi[WIDTH-1:0], accLo[WIDTH-1]};
    divDiff  = divShift - {1'b0, bMag};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isDiv <= 1'b0; negRes <= 1'b0; negRem <= 1'b0; divZero <= 1'b0;
      dividendRaw <= '0; bMag <= '0; accLo <= '0; accHi <= '0;
    end else if (strobes.load) begin
      isDiv       <= opSel[1];
      negRes      <= aNeg ^ bNeg;
      negRem      <= aNeg;
      divZero     <= (srcB == '0);
      dividendRaw <= srcA;
      bMag        <= bMagIn;
      accLo       <= aMag;
      accHi       <= '0;
    end else if (strobes.step) begin
      if (isDiv) begin
        if (!divDiff[WIDTH]) begin
          accHi <= divDiff;
          accLo <= {accLo[WIDTH-2:0], 1'b1};
        end else begin
          accHi <= divShift;
          accLo <= {accLo[WIDTH-2:0], 1'b0};
        end
      end else begin
        accHi <= {1'b0, mulSum[WIDTH:1]};
        accLo <= {mulSum[0], accLo[WIDTH-1:1]};
      end
    end
  end

  // result formation from magnitudes
  logic [DW-1:0]    prodMag, prodFix;
  logic [WIDTH-1:0] quoFix, remFix;
  always_comb begin
    prodMag = {accHi[WIDTH-1:0], accLo};
    prodFix = negRes ? (~prodMag + 1'b1) : prodMag;
    quoFix  = negRes ? (~accLo + 1'b1) : accLo;
    remFix  = negRem ? (~accHi[WIDTH-1:0] + 1'b1) : accHi[WIDTH-1:0];
    if (!isDiv) begin
      resHi = prodFix[DW-1:WIDTH];
      resLo = prodFix[WIDTH-1:0];
    end else if (divZero) begin
      resHi = dividendRaw;
      resLo = '1;
    end else begin
      resHi = remFix;
      resLo = quoFix;
    end
  end
endmodule

// File: rtl/muldiv_hilo_regs.sv
module muldiv_hilo_regs
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdStrobe_t        strobes,
  input  logic [WIDTH-1:0] resHi,
  input  logic [WIDTH-1:0] resLo,
  output logic [WIDTH-1:0] hiReg,
  output logic [WIDTH-1:0] loReg
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
    end else if (strobes.commit) begin
      hiReg <= resHi;
      loReg <= resLo;
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);
  mdStrobe_t        strobes;
  logic [WIDTH-1:0] resHi, resLo;

  muldiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .strobes(strobes), .busy(busy), .done(done)
  );

  muldiv_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .resHi(resHi), .resLo(resLo)
  );

  muldiv_hilo_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .resHi(resHi), .resLo(resLo), .hiReg(hiOut), .loReg(loOut)
  );
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hiOut,
  input logic [WIDTH-1:0] loOut
);
  // R7: completion pulse lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: done never overlaps busy
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R7: busy only falls together with a completion
  a_r7_busy_ends_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R7: busy only rises after a start request
  a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));
  // R8: a start during a computation does not cut it short
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> (busy || done));
  // R9: HI and LO only change on completion
  a_r9_hi_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(hiOut));
  a_r9_lo_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(loOut));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy),
  .done(done), .hiOut(hiOut), .loOut(loOut)
);

// File: tb/muldiv_hilo_bench.sv
module muldiv_hilo_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic [31:0] srcA = '0, srcB = '0;
  logic        busy, done;
  logic [31:0] hiOut, loOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cycles <= cycles + 1;

  muldiv_hilo u_muldiv_hilo (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .busy(busy), .done(done),
    .hiOut(hiOut), .loOut(loOut)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string opReq(input logic [1:0] op, input logic [31:0] b);
    if (op[1] && b == 0) return "R6";
    case (op)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // reference results from the requirement text
  function automatic logic [63:0] refModel(input logic [1:0] op,
                                           input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    longint unsigned ua, ub;
    logic [63:0] p;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = {32'd0, a};           ub = {32'd0, b};
    case (op)
      2'd0: p = 64'(sa * sb);
      2'd1: p = ua * ub;
      default: begin
        if (b == 0) p = {a, 32'hFFFF_FFFF};
        else if (op == 2'd2) begin
          q = sa / sb; r = sa % sb;
          p = {r[31:0], q[31:0]};
        end else begin
          p = {32'(ua % ub), 32'(ua / ub)};
        end
      end
    endcase
    return p;
  endfunction

  // run one operation; optionally fire a stray start mid-run
  task automatic runOp(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input bit stray);
    logic [63:0] prevHL, expHL;
    int busyCnt;
    string rq;
    rq = opReq(op, b);
    expHL = refModel(op, a, b);
    @(negedge clk);
    prevHL = {hiOut, loOut};
    startReq = 1'b1; opSel = op; srcA = a; srcB = b;
    @(negedge clk);
    startReq = 1'b0;
    busyCnt = 0;
    for (int i = 0; i < 60 && !done; i++) begin
      if (busy) busyCnt++;
      if (busy && {hiOut, loOut} !== prevHL)
        check("R9", "HI/LO changed during computation", {hiOut, loOut}, prevHL);
      if (stray && busyCnt == 10) begin
        startReq = 1'b1; opSel = ~op; srcA = ~a; srcB = b ^ 32'h55;
      end else begin
        startReq = 1'b0;
      end
      @(negedge clk);
    end
    startReq = 1'b0;
    check("R7", "done seen with busy low", {62'd0, done, busy}, 64'd2);
    check(stray ? "R8" : "R7", "busy cycle count", 64'(busyCnt), 64'd33);
    check(rq, "result {HI,LO}", {hiOut, loOut}, expHL);
    @(negedge clk);
    check(stray ? "R8" : "R7", "done pulse ended, idle",
          {62'd0, done, busy}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "reset busy/done", {62'd0, busy, done}, 64'd0);
    check("R1", "reset HI/LO", {hiOut, loOut}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", {62'd0, busy, done}, 64'd0);
    // directed corners
    runOp(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);   // R2 -1*-1
    runOp(2'd0, 32'h8000_0000, 32'h8000_0000, 0);   // R2
    runOp(2'd0, 32'h8000_0000, 32'd7, 0);           // R2 mixed sign
    runOp(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);   // R3
    runOp(2'd1, 32'h1234_5678, 32'd0, 0);           // R3 zero
    runOp(2'd2, 32'hFFFF_FFF9, 32'd2, 0);           // R4 -7/2
    runOp(2'd2, 32'd7, 32'hFFFF_FFFE, 0);           // R4 7/-2
    runOp(2'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 0);   // R4 -7/-2
    runOp(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 0);   // R4 overflow case
    runOp(2'd3, 32'hFFFF_FFFF, 32'd3, 0);           // R5
    runOp(2'd3, 32'd5, 32'd9, 0);                   // R5 quotient 0
    runOp(2'd3, 32'hDEAD_BEEF, 32'd0, 0);           // R6 unsigned
    runOp(2'd2, 32'h8765_4321, 32'd0, 0);           // R6 signed
    runOp(2'd0, 32'd12345, 32'hFFFF_0000, 1);       // R8 stray start
    runOp(2'd2, 32'hF000_0001, 32'd3, 1);           // R8 stray start
    // constrained random
    for (int n = 0; n < 200; n++) begin
      logic [31:0] ra, rb;
      logic [1:0] rop;
      rop = 2'($urandom_range(0, 3));
      ra  = $urandom();
      rb  = $urandom();
      if (n % 5 == 1) rb = rb & 32'hFF;
      if (n % 17 == 3) rb = 32'd0;
      runOp(rop, ra, rb, (n % 9 == 4));
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule